// File: doc/BRIEF.md
# Buffered I2C Master Read Sequencer

This block runs the read side of an I2C master on behalf of a host. The host writes three registers: a target byte (address plus direction bit), a block-length register (a 7-bit byte count and a final-byte-refuse flag), and a control register (begin, halt and interrupt-pending bits). The block issues START or repeated START and sends the address. It then clocks in a whole block of bytes into a small receive store before it interrupts the host again. It ACKs each byte, or NACKs only the last one when the flag asks for it.

At every defined point the block posts an 8-bit status code and raises `irq`. While `irq` is pending, SCL stays low, so the bus waits for the host. The host acts by writing the control register with the pending bit at 0. The block drives the open-drain lines only through output enables. It watches SDA for lost arbitration. An address with the write bit is not served: the block raises a handoff flag and holds the bus for a separate transmit engine.

Top module: `i2c_rx_seq`

## Requirements
- R1: After reset, `status` is F8h, `irq` is 0, `handoff` is 0 and neither line enable is asserted.
- R2: When idle, with the begin bit (control bit 5) set and both lines high, a START is generated and `status` becomes 08h with `irq` high. While `irq` is high and the status is not 38h, `scl_oe` stays asserted.
- R3: The low three bits of `status` are always 0, and `irq` is never high together with F8h.
- R4: Register selects are 0 target, 1 block length (bit 7 refuse-last flag, bits 6:0 count) and 2 control (bit 5 begin, bit 4 halt, bit 3 pending). From 08h/10h, clearing pending with an odd target sends it and receives count bytes. Byte k of a block lands at store index k mod DEPTH.
- R5: With the flag at 0, every byte is ACKed and the block ends in 50h.
- R6: With the flag at 1, the final byte alone is NACKed and the block ends in 58h.
- R7: If the target byte is NACKed, the status becomes 48h.
- R8: In 50h, reloading the length and clearing pending receives a further block with no new START.
- R9: In 48h/58h the action on clearing pending depends on begin and halt. Begin only gives a repeated START (10h). Halt only gives a STOP, after which the halt bit reads 0 and the status is F8h. Both give a STOP then a START (08h). Neither is ignored, and `irq` stays high.
- R10: If a released SDA reads low while SCL is high, the status becomes 38h and both enables drop. Clearing pending with begin at 0 leaves the block idle. With begin at 1, a START follows once both lines are high.
- R11: An even target in 08h/10h raises `handoff` with F8h and no interrupt, and SCL stays held. Setting halt then sends a STOP and drops `handoff`.
- R12: A count of 0 in 08h/10h/50h starts no read. The block sends a STOP and reports F8h with no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 2 | Register select: 0 target, 1 length, 2 control |
| wr_data | input | 8 | Host write data |
| status | output | 8 | Status code |
| irq | output | 1 | Interrupt pending |
| sto_pending | output | 1 | Halt bit readback |
| rd_idx | input | AW | Receive store read index |
| rd_data | output | 8 | Receive store read data |
| handoff | output | 1 | Transmit handoff active |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
The assertions assume that the host writes the control register only in a way the block defines: it clears pending only while `irq` is high, and it drops begin in the write that answers 08h or 10h. They also assume that the line inputs follow a wired-AND of the block's enables and the other agents. The bench keeps to this by modelling the bus as a pull-up combined with the enables, a responding target and an extra agent that pulls SDA low. It issues host writes only from the documented states.

// File: rtl/i2c_rx_seq.sv
module i2c_rx_seq #(
  parameter int QTR = 5,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = $clog2(QTR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [7:0]    wr_data,
  output logic [7:0]    status,
  output logic          irq,
  output logic          sto_pending,
  input  logic [AW-1:0] rd_idx,
  output logic [7:0]    rd_data,
  output logic          handoff,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe
);

  localparam logic [7:0] ST_S   = 8'h08;
  localparam logic [7:0] ST_RS  = 8'h10;
  localparam logic [7:0] ST_AL  = 8'h38;
  localparam logic [7:0] ST_AN  = 8'h48;
  localparam logic [7:0] ST_OK  = 8'h50;
  localparam logic [7:0] ST_NK  = 8'h58;
  localparam logic [7:0] ST_NO  = 8'hF8;

  typedef enum logic [2:0] {S_IDLE, S_START, S_ADDR, S_DATA, S_STOP, S_WAIT, S_LOST, S_HAND} st_t;

  st_t st;
  logic [1:0] q;
  logic [DW-1:0] div;
  logic [3:0] bitn;
  logic [7:0] sh, addr_r, stat;
  logic [6:0] bc_r, left;
  logic lb_r, sta_r, sto_r, si, ackn, rep, scl_d, sda_d;
  logic [AW-1:0] wptr;
  logic [7:0] mem [DEPTH];

  wire tick     = (div == DW'(QTR - 1));
  wire kick     = wr_en && (wr_sel == 2'd2) && !wr_data[3] && si;
  wire nack_now = lb_r && (left == 7'd1);
  wire store    = tick && (st == S_DATA) && (q == 2'd3) && (bitn == 4'd7);

  assign status      = stat;
  assign irq         = si;
  assign sto_pending = sto_r;
  assign handoff     = (st == S_HAND);
  assign scl_oe      = scl_d;
  assign sda_oe      = sda_d;
  assign rd_data     = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (store) mem[wptr] <= sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; q <= '0; div <= '0; bitn <= '0; sh <= '0;
      addr_r <= '0; bc_r <= '0; lb_r <= 1'b0; sta_r <= 1'b0; sto_r <= 1'b0;
      si <= 1'b0; stat <= ST_NO; ackn <= 1'b0; rep <= 1'b0; left <= '0;
      wptr <= '0; scl_d <= 1'b0; sda_d <= 1'b0;
    end else begin
      div <= tick ? '0 : div + 1'b1;
      if (wr_en) begin
        case (wr_sel)
          2'd0: addr_r <= wr_data;
          2'd1: {lb_r, bc_r} <= wr_data;
          2'd2: begin sta_r <= wr_data[5]; sto_r <= wr_data[4]; end
          default: ;
        endcase
      end
      case (st)
        S_IDLE: begin
          scl_d <= 1'b0;
          sda_d <= 1'b0;
          if (tick && sta_r && scl_in && sda_in) begin
            st <= S_START; q <= '0; rep <= 1'b0;
          end
        end
        S_START: if (tick) begin
          q <= q + 2'd1;
          case (q)
            2'd0: sda_d <= 1'b0;
            2'd1: scl_d <= 1'b0;
            2'd2: sda_d <= 1'b1;
            default: begin
              scl_d <= 1'b1; si <= 1'b1; st <= S_WAIT;
              stat <= rep ? ST_RS : ST_S;
            end
          endcase
        end
        S_WAIT: if (kick) begin
          if (stat == ST_S || stat == ST_RS || stat == ST_OK) begin
            si <= 1'b0; stat <= ST_NO; q <= '0; bitn <= '0; left <= bc_r; wptr <= '0;
            if (bc_r == 7'd0) st <= S_STOP;
            else if (stat == ST_OK) st <= S_DATA;
            else if (!addr_r[0]) st <= S_HAND;
            else begin st <= S_ADDR; sh <= addr_r; end
          end else if (wr_data[5] || wr_data[4]) begin
            si <= 1'b0; stat <= ST_NO; q <= '0; rep <= 1'b1;
            st <= wr_data[4] ? S_STOP : S_START;
          end
        end
        S_ADDR: if (tick) begin
          q <= q + 2'd1;
          case (q)
            2'd0: sda_d <= (bitn < 4'd8) ? ~sh[7] : 1'b0;
            2'd1: scl_d <= 1'b0;
            2'd2: begin
              if (bitn < 4'd8) begin
                if (sh[7] && !sda_in) begin
                  st <= S_LOST; scl_d <= 1'b0; sda_d <= 1'b0; stat <= ST_AL; si <= 1'b1;
                end
              end else ackn <= sda_in;
            end
            default: begin
              scl_d <= 1'b1;
              if (bitn < 4'd8) begin
                sh <= {sh[6:0], 1'b0}; bitn <= bitn + 4'd1;
              end else if (ackn) begin
                stat <= ST_AN; si <= 1'b1; st <= S_WAIT;
              end else begin
                bitn <= '0; st <= S_DATA;
              end
            end
          endcase
        end
        S_DATA: if (tick) begin
          q <= q + 2'd1;
          case (q)
            2'd0: sda_d <= (bitn == 4'd8) ? ~nack_now : 1'b0;
            2'd1: scl_d <= 1'b0;
            2'd2: begin
              if (bitn < 4'd8) sh <= {sh[6:0], sda_in};
              else if (nack_now && !sda_in) begin
                st <= S_LOST; scl_d <= 1'b0; sda_d <= 1'b0; stat <= ST_AL; si <= 1'b1;
              end
            end
            default: begin
              scl_d <= 1'b1;
              if (bitn < 4'd8) begin
                bitn <= bitn + 4'd1;
                if (bitn == 4'd7) wptr <= wptr + AW'(1);
              end else begin
                left <= left - 7'd1; bitn <= '0;
                if (left == 7'd1) begin
                  stat <= lb_r ? ST_NK : ST_OK; si <= 1'b1; st <= S_WAIT;
                end
              end
            end
          endcase
        end
        S_STOP: if (tick) begin
          q <= q + 2'd1;
          case (q)
            2'd0: sda_d <= 1'b1;
            2'd1: scl_d <= 1'b0;
            2'd2: sda_d <= 1'b0;
            default: begin sto_r <= 1'b0; st <= S_IDLE; end
          endcase
        end
        S_LOST: begin
          scl_d <= 1'b0;
          sda_d <= 1'b0;
          if (kick) begin si <= 1'b0; stat <= ST_NO; st <= S_IDLE; end
        end
        S_HAND: if (sto_r) begin st <= S_STOP; q <= '0; end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_status_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status[2:0] == 3'b000);
  assert_no_irq_on_f8_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status != ST_NO);
  assert_scl_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && status != ST_AL) |-> scl_oe);
  assert_lost_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_AL) |-> (!scl_oe && !sda_oe));
  assert_handoff_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    handoff |-> (!irq && scl_oe));

endmodule

// File: tb/i2c_rx_seq_tb.sv
`timescale 1ns/1ps
module i2c_rx_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_idx = '0;
  logic [7:0] status, rd_data;
  logic irq, sto_pending, handoff, scl_oe, sda_oe;
  logic s_low = 1'b0, x_low = 1'b0, ack_addr = 1'b1;
  int total = 0, bad = 0;

  wire scl_w = ~scl_oe;
  wire sda_w = ~(sda_oe | s_low | x_low);

  always #10 clk = ~clk;

  i2c_rx_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .status(status), .irq(irq), .sto_pending(sto_pending), .rd_idx(rd_idx),
    .rd_data(rd_data), .handoff(handoff), .scl_in(scl_w), .sda_in(sda_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  function automatic logic [7:0] sdat(input int k);
    return 8'h5A ^ (8'(k) * 8'd13);
  endfunction

  // responding target: 0 idle, 1 address, 2 reading
  int phase = 0, bcnt = 0, kidx = 0;
  logic first = 1'b0, ps = 1'b1, pd = 1'b1;
  logic [7:0] ashift = '0;
  logic acks [0:31];

  always @(scl_w, sda_w) begin
    if (scl_w && ps && (sda_w != pd)) begin
      if (!sda_w) begin phase = 1; bcnt = 0; kidx = 0; first = 1'b1; s_low = 1'b0; end
      else begin phase = 0; s_low = 1'b0; end
    end else if (scl_w && !ps) begin
      if (phase == 1 && bcnt < 8) ashift = {ashift[6:0], sda_w};
      else if (phase == 2 && bcnt == 8) begin
        acks[kidx] = sda_w;
        if (sda_w) phase = 0; else kidx = kidx + 1;
      end
    end else if (!scl_w && ps) begin
      if (first) first = 1'b0;
      else if (bcnt == 8) begin
        bcnt = 0;
        if (phase == 1) phase = (ack_addr && ashift[0]) ? 2 : 0;
      end else bcnt = bcnt + 1;
      if (phase == 1) s_low = (bcnt == 8) ? ack_addr : 1'b0;
      else if (phase == 2) s_low = (bcnt < 8) ? ~sdat(kidx)[7 - bcnt] : 1'b0;
      else s_low = 1'b0;
    end
    ps = scl_w;
    pd = sda_w;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_irq(input string tag);
    int n = 0;
    while (!irq && n < 20000) begin @(negedge clk); n++; end
    chk(irq, {tag, " irq timeout"}, irq, 1);
  endtask

  task automatic exp_stat(input logic [7:0] e, input string tag);
    chk(status == e, tag, status, e);
    chk(status[2:0] == 3'b000, "R3 low bits", status[2:0], 0);
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while ((scl_oe || sda_oe || sto_pending || status != 8'hF8) && n < 20000) begin
      @(negedge clk); n++;
    end
    chk(!scl_oe && !sda_oe, {tag, " lines released"}, {scl_oe, sda_oe}, 0);
    chk(!sto_pending, {tag, " halt bit cleared"}, sto_pending, 0);
    exp_stat(8'hF8, {tag, " idle status"});
    chk(!irq, {tag, " no irq"}, irq, 0);
  endtask

  task automatic chk_buf(input int idx, input int k, input string tag);
    rd_idx = 3'(idx);
    #1;
    chk(rd_data == sdat(k), tag, rd_data, sdat(k));
  endtask

  task automatic t_reset();
    exp_stat(8'hF8, "R1 reset status");
    chk(!irq && !handoff, "R1 reset irq/handoff", {irq, handoff}, 0);
    chk(!scl_oe && !sda_oe, "R1 reset lines", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_two_blocks();
    ack_addr = 1'b1;
    wr(2, 8'h20);
    wait_irq("R2 start");
    exp_stat(8'h08, "R2 start status");
    repeat (40) @(negedge clk);
    chk(scl_oe && irq, "R2 scl held", scl_oe, 1);
    wr(0, 8'hA1); wr(1, 8'h03); wr(2, 8'h00);
    wait_irq("R5 block");
    exp_stat(8'h50, "R5 all acked status");
    for (int i = 0; i < 3; i++) begin
      chk_buf(i, i, "R4 block data");
      chk(acks[i] == 1'b0, "R5 ack per byte", acks[i], 0);
    end
    wr(1, 8'h84); wr(2, 8'h00);
    wait_irq("R8 second block");
    exp_stat(8'h58, "R6 last nacked status");
    for (int i = 0; i < 4; i++) chk_buf(i, 3 + i, "R8 second block data");
    chk(acks[5] == 1'b0, "R6 ack before last", acks[5], 0);
    chk(acks[6] == 1'b1, "R6 nack on last", acks[6], 1);
    wr(2, 8'h00);
    repeat (60) @(negedge clk);
    chk(irq && scl_oe, "R9 neither bit ignored", irq, 1);
    exp_stat(8'h58, "R9 status kept");
    wr(2, 8'h10);
    chk(sto_pending, "R9 halt bit set", sto_pending, 1);
    wait_idle("R9 stop only");
  endtask

  task automatic t_nack_rs_handoff();
    ack_addr = 1'b0;
    wr(2, 8'h20);
    wait_irq("R2 start");
    exp_stat(8'h08, "R2 start status b");
    wr(0, 8'hA1); wr(1, 8'h02); wr(2, 8'h00);
    wait_irq("R7 addr nack");
    exp_stat(8'h48, "R7 address nack status");
    wr(2, 8'h20);
    wait_irq("R9 repeated start");
    exp_stat(8'h10, "R9 repeated start status");
    wr(0, 8'hA0); wr(1, 8'h05); wr(2, 8'h00);
    repeat (3) @(negedge clk);
    chk(handoff, "R11 handoff raised", handoff, 1);
    exp_stat(8'hF8, "R11 handoff status");
    chk(!irq && scl_oe, "R11 no irq scl held", {irq, scl_oe}, 1);
    wr(2, 8'h10);
    wait_idle("R11 handoff stop");
    chk(!handoff, "R11 handoff dropped", handoff, 0);
  endtask

  task automatic t_wrap_stopstart();
    ack_addr = 1'b1;
    wr(2, 8'h20);
    wait_irq("R2 start");
    wr(0, 8'hA1); wr(1, 8'h8A); wr(2, 8'h00);
    wait_irq("R4 long block");
    exp_stat(8'h58, "R6 long block status");
    chk_buf(0, 8, "R4 wrap index 0");
    chk_buf(1, 9, "R4 wrap index 1");
    chk_buf(2, 2, "R4 wrap index 2");
    chk(acks[9] == 1'b1, "R6 nack last of ten", acks[9], 1);
    wr(2, 8'h30);
    wait_irq("R9 stop then start");
    exp_stat(8'h08, "R9 stop+start status");
    chk(!sto_pending, "R9 halt cleared after stop", sto_pending, 0);
    wr(1, 8'h00); wr(2, 8'h00);
    repeat (3) @(negedge clk);
    chk(!irq, "R12 zero count no irq", irq, 0);
    exp_stat(8'hF8, "R12 zero count status");
    wait_idle("R12 zero count stop");
  endtask

  task automatic t_arb();
    ack_addr = 1'b1;
    wr(2, 8'h20);
    wait_irq("R2 start");
    x_low = 1'b1;
    wr(0, 8'hA1); wr(1, 8'h01); wr(2, 8'h00);
    wait_irq("R10 lost");
    exp_stat(8'h38, "R10 lost status");
    chk(!scl_oe && !sda_oe, "R10 lines released", {scl_oe, sda_oe}, 0);
    wr(2, 8'h20);
    repeat (100) @(negedge clk);
    chk(!irq, "R10 waits for free bus", irq, 0);
    exp_stat(8'hF8, "R10 waiting status");
    x_low = 1'b0;
    wait_irq("R10 retry");
    exp_stat(8'h08, "R10 retry start");
    wr(1, 8'h00); wr(2, 8'h00);
    wait_idle("R10 finish");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) acks[i] = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_two_blocks();
    t_nack_rs_handoff();
    t_wrap_stopstart();
    t_arb();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule